// File: doc/BRIEF.md
# Calibration Pulse-to-Trigger Delay Generator

This block emits a single calibration test-pulse strobe and, a programmable time later, a trigger strobe. A front end that is being calibrated uses it: the injected charge follows the test pulse, and the trigger reads the front end back. Scanning the spacing between the two strobes traces the shaped analogue pulse. The spacing can be set in 1 ns steps. A coarse part counts periods of the 5 ns base clock. A fine part selects a sub-period tap of an external delay line, and the block only drives the select code for that line. A fixed intrinsic latency, set by a parameter with a default of 133 base cycles, always lies under the programmed spacing.

A start command captures a calibration-enable bit, a 6-bit coarse count and a 3-bit fine code. With enable low, the programmed delay is not applied: only the intrinsic latency separates the strobes, and the fine tap is zero. The block fires the test pulse once per accepted command and reports busy until the trigger has been issued. A start that arrives while the block is busy has no effect.

Top module: `tp_trig_delay`

## Requirements
- R1: While reset is high, and on the first cycle after it falls, test_pulse, trigger and busy are 0 and fine_tap is 0.
- R2: A start that is sampled high at a clock edge while busy is low is accepted. After that edge, test_pulse is high for exactly one cycle.
- R3: With cal_en=1, trigger is high for one cycle exactly LATENCY + coarse cycles after the test_pulse cycle (LATENCY defaults to 133; coarse is 0 to 63).
- R4: With cal_en=0, trigger comes exactly LATENCY cycles after test_pulse, whatever the coarse value. fine_tap is 0.
- R5: With cal_en=1, fine_tap equals fine when fine is 0 to 4 and equals 4 when fine is 5 to 7. It changes in the same cycle as test_pulse and holds until the next accepted start.
- R6: busy is high from the test_pulse cycle through the trigger cycle inclusive, and low in the cycle after trigger.
- R7: A start that arrives while busy is high is ignored. It produces no test_pulse, does not move the pending trigger, and does not change fine_tap.
- R8: cal_en, coarse and fine are captured only at acceptance. Changes to them afterwards do not affect the pending trigger or fine_tap.
- R9: Each accepted command yields exactly one test_pulse and one trigger. Neither strobe appears at any other time.
- R10: A start in the cycle right after trigger, when busy is already low, is accepted. A start in the trigger cycle itself is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 200 MHz base clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Command to begin one pulse/trigger sequence |
| cal_en | input | 1 | 1 applies the programmed delay, 0 uses the intrinsic latency only |
| coarse | input | 6 | Added delay in base clock periods |
| fine | input | 3 | Sub-period delay code in 1 ns steps, limited to 4 |
| test_pulse | output | 1 | One-cycle calibration injection strobe |
| trigger | output | 1 | One-cycle readout trigger strobe |
| fine_tap | output | 3 | Tap select for the external fine delay line |
| busy | output | 1 | A sequence is in progress |

## Verification
When a start is accepted, the bench records the cycle stamp of that edge. It expects test_pulse one cycle later, trigger LATENCY plus the effective coarse count cycles after test_pulse, and the tap code together with test_pulse. The driver pushes these stamps into a queue as it issues each command. The monitor samples on the falling edge, compares each strobe against the stamp at the head of the queue, and checks busy and fine_tap on every cycle against the window that the queue implies. Starts that land inside that window, including one on the trigger cycle itself, push nothing, so any strobe they cause shows up as a cycle mismatch.

// File: rtl/tpd_pkg.sv
package tpd_pkg;
  typedef enum logic {
    TPD_IDLE  = 1'b0,
    TPD_ARMED = 1'b1
  } tpd_state_e;
endpackage

// File: rtl/tpd_field_decode.sv
module tpd_field_decode #(
  parameter int CW       = 6,
  parameter int FW       = 3,
  parameter int FINE_MAX = 4,
  parameter int LATENCY  = 133,
  parameter int DW       = 8
) (
  input  logic          cal_en,
  input  logic [CW-1:0] coarse,
  input  logic [FW-1:0] fine,
  output logic [DW-1:0] cycles,
  output logic [FW-1:0] tap
);
  localparam int FINE_CODES = 1 << FW;

  logic [FW-1:0] fine_lim;

  generate
    if (FINE_MAX >= FINE_CODES - 1) begin : g_no_clamp
      assign fine_lim = fine;
    end else begin : g_clamp
      assign fine_lim = (fine > FW'(FINE_MAX)) ? FW'(FINE_MAX) : fine;
    end
  endgenerate

  always_comb begin
    cycles = DW'(LATENCY);
    tap    = '0;
    if (cal_en) begin
      cycles = DW'(LATENCY) + DW'(coarse);
      tap    = fine_lim;
    end
  end
endmodule

// File: rtl/tpd_countdown.sv
module tpd_countdown #(
  parameter int DW    = 8,
  parameter int MAX_D = 196
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  output logic          expire
);
  logic [DW-1:0] cnt;
  logic          active;

  assign expire = active && (cnt == DW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      active <= 1'b0;
    end else if (load) begin
      cnt    <= load_val;
      active <= 1'b1;
    end else if (active) begin
      cnt <= cnt - DW'(1);
      if (cnt == DW'(1)) active <= 1'b0;
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    active |-> (cnt != '0) && (cnt <= DW'(MAX_D))); // R3
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    active && !expire && !load |=> active && (cnt == $past(cnt) - DW'(1))); // R3
endmodule

// File: rtl/tp_trig_delay.sv
module tp_trig_delay #(
  parameter int LATENCY = 133,
  parameter int CW      = 6,
  parameter int FW      = 3,
  parameter int CLK_NS  = 5,
  parameter int FINE_NS = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          cal_en,
  input  logic [CW-1:0] coarse,
  input  logic [FW-1:0] fine,
  output logic          test_pulse,
  output logic          trigger,
  output logic [FW-1:0] fine_tap,
  output logic          busy
);
  import tpd_pkg::*;

  localparam int FINE_MAX = CLK_NS / FINE_NS - 1;
  localparam int MAX_D    = LATENCY + (1 << CW) - 1;
  localparam int DW       = $clog2(MAX_D + 1);

  tpd_state_e    state;
  logic          accept;
  logic          expire;
  logic [DW-1:0] dec_cycles;
  logic [FW-1:0] dec_tap;

  assign accept = start && (state == TPD_IDLE);
  assign busy   = (state == TPD_ARMED);

  tpd_field_decode #(
    .CW(CW), .FW(FW), .FINE_MAX(FINE_MAX), .LATENCY(LATENCY), .DW(DW)
  ) u_decode (
    .cal_en(cal_en),
    .coarse(coarse),
    .fine  (fine),
    .cycles(dec_cycles),
    .tap   (dec_tap)
  );

  tpd_countdown #(.DW(DW), .MAX_D(MAX_D)) u_count (
    .clk     (clk),
    .rst     (rst),
    .load    (accept),
    .load_val(dec_cycles),
    .expire  (expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= TPD_IDLE;
      test_pulse <= 1'b0;
      trigger    <= 1'b0;
      fine_tap   <= '0;
    end else begin
      test_pulse <= 1'b0;
      trigger    <= expire;
      if (accept) begin
        state      <= TPD_ARMED;
        test_pulse <= 1'b1;
        fine_tap   <= dec_tap;
      end else if (trigger) begin
        state <= TPD_IDLE;
      end
    end
  end

  AST_TP_SINGLE: assert property (@(posedge clk) disable iff (rst)
    test_pulse |=> !test_pulse); // R9
  AST_TP_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
    test_pulse |-> !$past(busy)); // R7
  AST_BUSY_WITH_TP: assert property (@(posedge clk) disable iff (rst)
    test_pulse |-> busy); // R6
  AST_TRIG_RELEASE: assert property (@(posedge clk) disable iff (rst)
    trigger |=> !busy); // R6
  AST_TRIG_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
    trigger |-> busy && !test_pulse); // R9
  AST_TAP_LIMIT: assert property (@(posedge clk) disable iff (rst)
    fine_tap <= FW'(FINE_MAX)); // R5
  AST_TAP_HELD: assert property (@(posedge clk) disable iff (rst)
    busy && !test_pulse |-> $stable(fine_tap)); // R8
endmodule

// File: tb/sim_tp_trig_delay.sv
module sim_tp_trig_delay;
  localparam int LAT = 133;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic       cal_en = 1'b0;
  logic [5:0] coarse = '0;
  logic [2:0] fine = '0;
  logic       test_pulse, trigger, busy;
  logic [2:0] fine_tap;

  tp_trig_delay u0 (
    .clk(clk), .rst(rst), .start(start), .cal_en(cal_en),
    .coarse(coarse), .fine(fine), .test_pulse(test_pulse),
    .trigger(trigger), .fine_tap(fine_tap), .busy(busy)
  );

  always #2 clk = ~clk;

  typedef struct { int tp; int trg; int tap; } exp_t;
  exp_t q[$];
  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  int last_trig = -1;
  int cur_tap = 0;
  bit mon_on = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic next_cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic wait_to(input int n);
    while (cyc < n) next_cyc();
  endtask

  // Driver: issues one start pulse and pushes the expected item if accepted.
  task automatic issue(input bit ce, input int co, input int fi);
    exp_t e;
    int d, t;
    start = 1'b1; cal_en = ce; coarse = 6'(co); fine = 3'(fi);
    if (cyc > last_trig) begin
      check(busy == 1'b0, "R2 idle before accept", busy, 0);
      d = LAT + (ce ? co : 0);
      t = ce ? ((fi > 4) ? 4 : fi) : 0;
      e.tp = cyc + 1; e.trg = cyc + 1 + d; e.tap = t;
      q.push_back(e);
      last_trig = e.trg;
    end else begin
      check(busy == 1'b1, "R7 busy when start ignored", busy, 1);
    end
    next_cyc();
    start = 1'b0;
  endtask

  // Monitor: compares strobes and per-cycle state against the queue.
  always @(negedge clk) begin
    if (mon_on) begin
      automatic bit exp_busy = (q.size() > 0) && (cyc >= q[0].tp) && (cyc <= q[0].trg);
      check(busy == exp_busy, "R6 busy window", busy, exp_busy);
      if (test_pulse) begin
        if (q.size() == 0) check(1'b0, "R9 unexpected test_pulse", 1, 0);
        else begin
          check(cyc == q[0].tp, "R2 test_pulse cycle", cyc, q[0].tp);
          check(int'(fine_tap) == q[0].tap, "R5 fine_tap value", fine_tap, q[0].tap);
          cur_tap = q[0].tap;
        end
      end else begin
        check(int'(fine_tap) == cur_tap, "R8 fine_tap held", fine_tap, cur_tap);
      end
      if (trigger) begin
        if (q.size() == 0) check(1'b0, "R9 unexpected trigger", 1, 0);
        else begin
          check(cyc == q[0].trg, "R3 trigger cycle", cyc, q[0].trg);
          void'(q.pop_front());
        end
      end else if (q.size() > 0 && cyc == q[0].trg) begin
        check(1'b0, "R3 trigger missing", 0, 1);
        void'(q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog expired", cyc, 0);
    report();
    $finish;
  end

  task automatic drain();
    while (q.size() > 0) next_cyc();
    next_cyc();
  endtask

  initial begin
    repeat (3) next_cyc();
    check(!test_pulse && !trigger && !busy && fine_tap == 0, "R1 during reset", busy, 0);
    rst = 1'b0;
    next_cyc();
    check(!test_pulse && !trigger && !busy && fine_tap == 0, "R1 after reset", busy, 0);
    mon_on = 1'b1;

    issue(1'b1, 0, 0);  drain();          // R3 zero programmed delay
    issue(1'b1, 63, 4); drain();          // R3 max coarse, R5 fine at limit
    issue(1'b1, 17, 7); drain();          // R5 clamp 7 -> 4
    issue(1'b1, 5, 5);  drain();          // R5 clamp 5 -> 4
    issue(1'b1, 9, 3);  drain();          // R5 pass-through
    issue(1'b0, 40, 6); drain();          // R4 enable low

    // R7: start while busy with different fields is ignored
    issue(1'b1, 20, 2);
    repeat (10) next_cyc();
    issue(1'b1, 1, 4);
    issue(1'b0, 0, 0);
    drain();

    // R8: fields change right after acceptance
    issue(1'b1, 30, 1);
    cal_en = 1'b0; coarse = 6'd63; fine = 3'd4;
    drain();

    // R10: start on trigger cycle ignored, next cycle accepted
    issue(1'b1, 2, 2);
    wait_to(last_trig);
    issue(1'b1, 50, 3);
    issue(1'b1, 11, 1);
    drain();

    report();
    $finish;
  end
endmodule